// File: doc/BRIEF.md
# Prioritized Interrupt Level Evaluator with Vector Return

This block gathers every interrupt source a processor core can see and reduces them, each cycle, to the single priority level that is allowed to interrupt at the current processor priority. Hardware requests arrive from devices as set strobes. Each strobe names one of four bus levels (0x14 to 0x17) and one of 32 sources at that level. It also carries the source's base vector and a pattern of forced vector bits, which the block stores. A halt pin, a memory-error strobe and a software request summary (levels 1 to 15) compete with the hardware levels under a fixed precedence.

When the core takes an interrupt, it acknowledges the chosen level. One clock later the block presents a 9-bit vector and signals completion. For a hardware level it has already retired the lowest-numbered pending source at that level. For the memory-error level it clears the error flag and returns a fixed system vector. A bus reset empties every hardware pending register.

Top module: `irq_arbiter`

## Requirements
- R1: While `halt_in` is 1, `irq_lvl` is 0x1F regardless of every other input.
- R2: A pulse on `mem_err_set` sets a memory-error flag that persists. With the halt pin low, the flag set and `cur_ipl` below 0x1D, `irq_lvl` is 0x1D.
- R3: Otherwise hardware levels are scanned from 0x17 down to 0x14. A level at or below `cur_ipl` ends the scan with `irq_lvl` 0, and software requests are then ignored. The first level above `cur_ipl` with a pending source is reported.
- R4: If no hardware level is reported and the scan did not end early, software requests are considered only when `cur_ipl` is below 15. Bit k of `sw_req` (k = 1..15) requests level k. The highest requested level above `cur_ipl` is reported; if there is none, the output is 0.
- R5: An acknowledge (`ack_vld`) of hardware level 0x14+n (n = `set_lvl` index used when setting) selects the lowest-numbered pending source there and clears it. In the next cycle `ack_done` is 1 and `ack_vec` = (base | forced) & (forced | 0x1FC).
- R6: An acknowledge of a hardware level with nothing pending, or of any level that is neither a hardware level nor 0x1D, returns `ack_vec` 0 and clears nothing.
- R7: An acknowledge of level 0x1D returns vector 0x060 and clears the memory-error flag, unless `mem_err_set` is high in the same cycle.
- R8: When a set strobe and an acknowledge's clear hit the same source in the same cycle, the source stays pending and keeps the newly written vector. The acknowledge returns the vector stored before that edge.
- R9: A cycle with `bus_reset` high empties all hardware pending registers, and it takes precedence over a set strobe in that cycle. It leaves the memory-error flag unchanged.
- R10: After `rst_n` low, nothing is pending, the memory-error flag is clear, `ack_done` is 0 and `ack_vec` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_reset | input | 1 | Clears all hardware pending requests |
| halt_in | input | 1 | Halt pin, top precedence |
| mem_err_set | input | 1 | Sets the memory-error flag |
| cur_ipl | input | 5 | Current processor priority level |
| sw_req | input | 15 | Software requests, bit k = level k (indices 15:1) |
| set_vld | input | 1 | Hardware request set strobe |
| set_lvl | input | 2 | Hardware level index (0 = 0x14 ... 3 = 0x17) |
| set_src | input | 5 | Source number within the level |
| set_base | input | 9 | Base vector of the source |
| set_frc | input | 9 | Forced vector bits of the source |
| ack_vld | input | 1 | Acknowledge strobe |
| ack_lvl | input | 5 | Level being acknowledged |
| irq_lvl | output | 5 | Highest level allowed to interrupt, 0 if none |
| ack_done | output | 1 | Acknowledge completed (one cycle after `ack_vld`) |
| ack_vec | output | 9 | Vector returned by the acknowledge |

## Verification
The collision that matters is a set strobe landing on the very source that a simultaneous acknowledge retires. The bench provokes it by arming two sources at one level and then, in a single cycle, re-setting the lower one with a fresh vector while acknowledging that level. It judges the outcome from the vector of that acknowledge (the old one) and from two later acknowledges, which must return the re-set source's new vector and then the other source's vector. The memory-error strobe against its own acknowledge, and the bus reset against a set, are handled by the precedence rules in R7 and R9.

// File: rtl/irq_pkg.sv
// irq_pkg: constants shared by the interrupt evaluator and its checker.
// Assumes levels are 5-bit numbers and vectors are 9 bits wide.
package irq_pkg;
    localparam int          IPL_W      = 5;
    localparam int          VEC_W      = 9;
    localparam int          SW_TOP     = 15;
    localparam int          HW_BASE    = 'h14;
    localparam logic [4:0]  HALT_LVL   = 5'h1F;
    localparam logic [4:0]  MEMERR_LVL = 5'h1D;
    localparam logic [8:0]  VEC_KEEP   = 9'h1FC;
    localparam logic [8:0]  MEMERR_VEC = 9'h060;
endpackage

// File: rtl/irq_bank.sv
// irq_bank: pending-request register and vector store for one hardware level.
// Picks the lowest-numbered pending source and forms its vector combinationally.
// Assumes a set and a clear of the same bit in one cycle leave the bit set;
// a bus reset clears every pending bit and beats a set.
module irq_bank
    import irq_pkg::*;
#(
    parameter int NSRC = 32,
    localparam int SRC_W = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_reset,
    input  logic             set_hit,
    input  logic [SRC_W-1:0] set_src,
    input  logic [VEC_W-1:0] set_base,
    input  logic [VEC_W-1:0] set_frc,
    input  logic             clr_hit,
    output logic [NSRC-1:0]  pend,
    output logic             any,
    output logic [VEC_W-1:0] sel_vec
);
    logic [VEC_W-1:0] base_q [NSRC];
    logic [VEC_W-1:0] frc_q  [NSRC];
    logic [SRC_W-1:0] sel;
    logic [NSRC-1:0]  set_m;
    logic [NSRC-1:0]  clr_m;

    // Select the lowest-numbered pending source (the last match wins).
    always_comb begin
        sel = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (pend[i]) sel = SRC_W'(i);
        end
    end

    assign any     = |pend;
    assign sel_vec = (base_q[sel] | frc_q[sel]) & (frc_q[sel] | VEC_KEEP);

    // Build one-hot set and clear masks for this cycle.
    always_comb begin
        set_m = '0;
        clr_m = '0;
        if (set_hit)         set_m[set_src] = 1'b1;
        if (clr_hit && any)  clr_m[sel]     = 1'b1;
    end

    // Pending bits: reset and bus reset empty them, set overrides clear.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_reset) pend <= '0;
        else                     pend <= (pend & ~clr_m) | set_m;
    end

    // Capture the vector description of a source whenever it is set.
    always_ff @(posedge clk) begin
        if (set_hit) begin
            base_q[set_src] <= set_base;
            frc_q[set_src]  <= set_frc;
        end
    end
endmodule

// File: rtl/irq_prio.sv
// irq_prio: combinational precedence network. Order: halt pin, memory error
// below its level, hardware levels scanned downward with an early stop at the
// current priority, then software requests above the current priority.
module irq_prio
    import irq_pkg::*;
#(
    parameter int NLVL = 4
) (
    input  logic             halt_in,
    input  logic             mem_flag,
    input  logic [IPL_W-1:0] cur_ipl,
    input  logic [NLVL-1:0]  hw_any,
    input  logic [SW_TOP:1]  sw_req,
    output logic [IPL_W-1:0] lvl
);
    logic stop;

    // Resolve the single winning level for this cycle.
    always_comb begin
        lvl  = '0;
        stop = 1'b0;
        if (halt_in) begin
            lvl = HALT_LVL;
        end else if (mem_flag && (cur_ipl < MEMERR_LVL)) begin
            lvl = MEMERR_LVL;
        end else begin
            for (int i = NLVL - 1; i >= 0; i--) begin
                if (!stop) begin
                    if ((HW_BASE + i) <= int'(cur_ipl)) begin
                        stop = 1'b1;
                    end else if (hw_any[i]) begin
                        lvl  = IPL_W'(HW_BASE + i);
                        stop = 1'b1;
                    end
                end
            end
            if (!stop && (int'(cur_ipl) < SW_TOP)) begin
                for (int k = 1; k <= SW_TOP; k++) begin
                    if (sw_req[k] && (k > int'(cur_ipl))) lvl = IPL_W'(k);
                end
            end
        end
    end
endmodule

// File: rtl/irq_arbiter.sv
// irq_arbiter: top of the interrupt evaluator. Holds one bank per hardware
// level and the memory-error flag, reports the winning level continuously and
// answers an acknowledge with a registered vector one clock later.
// Assumes ack_lvl is stable for the cycle in which ack_vld is high.
module irq_arbiter
    import irq_pkg::*;
#(
    parameter int NLVL = 4,
    parameter int NSRC = 32,
    localparam int LVL_W = $clog2(NLVL),
    localparam int SRC_W = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_reset,
    input  logic             halt_in,
    input  logic             mem_err_set,
    input  logic [IPL_W-1:0] cur_ipl,
    input  logic [SW_TOP:1]  sw_req,
    input  logic             set_vld,
    input  logic [LVL_W-1:0] set_lvl,
    input  logic [SRC_W-1:0] set_src,
    input  logic [VEC_W-1:0] set_base,
    input  logic [VEC_W-1:0] set_frc,
    input  logic             ack_vld,
    input  logic [IPL_W-1:0] ack_lvl,
    output logic [IPL_W-1:0] irq_lvl,
    output logic             ack_done,
    output logic [VEC_W-1:0] ack_vec
);
    logic [NLVL*NSRC-1:0] pend_flat;
    logic [NLVL-1:0]      bank_any;
    logic [VEC_W-1:0]     bank_vec [NLVL];
    logic                 mem_q;
    logic                 ack_hw;
    logic                 ack_mem;
    logic [LVL_W-1:0]     ack_idx;
    logic [VEC_W-1:0]     vec_nxt;

    // Decode which kind of level the acknowledge targets.
    always_comb begin
        ack_hw  = ack_vld && (int'(ack_lvl) >= HW_BASE) && (int'(ack_lvl) < HW_BASE + NLVL);
        ack_mem = ack_vld && (ack_lvl == MEMERR_LVL);
        ack_idx = LVL_W'(int'(ack_lvl) - HW_BASE);
    end

    for (genvar g = 0; g < NLVL; g++) begin : g_bank
        irq_bank #(.NSRC(NSRC)) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .bus_reset(bus_reset),
            .set_hit  (set_vld && (set_lvl == LVL_W'(g))),
            .set_src  (set_src),
            .set_base (set_base),
            .set_frc  (set_frc),
            .clr_hit  (ack_hw && (ack_idx == LVL_W'(g))),
            .pend     (pend_flat[g*NSRC +: NSRC]),
            .any      (bank_any[g]),
            .sel_vec  (bank_vec[g])
        );
    end

    irq_prio #(.NLVL(NLVL)) u_prio (
        .halt_in (halt_in),
        .mem_flag(mem_q),
        .cur_ipl (cur_ipl),
        .hw_any  (bank_any),
        .sw_req  (sw_req),
        .lvl     (irq_lvl)
    );

    // Memory-error flag: a new error beats a same-cycle acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)           mem_q <= 1'b0;
        else if (mem_err_set) mem_q <= 1'b1;
        else if (ack_mem)     mem_q <= 1'b0;
    end

    // Choose the vector the acknowledge returns.
    always_comb begin
        vec_nxt = '0;
        if (ack_hw && bank_any[ack_idx]) vec_nxt = bank_vec[ack_idx];
        else if (ack_mem)                vec_nxt = MEMERR_VEC;
    end

    // Register the acknowledge result for one-clock completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_done <= 1'b0;
            ack_vec  <= '0;
        end else begin
            ack_done <= ack_vld;
            if (ack_vld) ack_vec <= vec_nxt;
        end
    end
endmodule

// File: rtl/irq_arbiter_chk.sv
// irq_arbiter_chk: temporal properties of the evaluator, bound to the top.
module irq_arbiter_chk
    import irq_pkg::*;
#(
    parameter int NLVL = 4,
    parameter int NSRC = 32
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_reset,
    input logic                 halt_in,
    input logic                 mem_err_set,
    input logic [IPL_W-1:0]     cur_ipl,
    input logic                 set_vld,
    input logic                 ack_vld,
    input logic [IPL_W-1:0]     ack_lvl,
    input logic [IPL_W-1:0]     irq_lvl,
    input logic                 ack_done,
    input logic [VEC_W-1:0]     ack_vec,
    input logic                 mem_q,
    input logic [NLVL*NSRC-1:0] pend_flat
);
    logic is_hw;
    logic lvl_busy;
    int   idx;

    // Locate the acknowledged hardware level and whether it holds a request.
    always_comb begin
        is_hw    = (int'(ack_lvl) >= HW_BASE) && (int'(ack_lvl) < HW_BASE + NLVL);
        idx      = is_hw ? int'(ack_lvl) - HW_BASE : 0;
        lvl_busy = |pend_flat[idx*NSRC +: NSRC];
    end

    p_halt_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        halt_in |-> irq_lvl == HALT_LVL);

    // Covers R3 and R4: nothing at or below the current priority is reported.
    p_above_ipl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_lvl != '0 && !halt_in) |-> irq_lvl > cur_ipl);

    p_ack_one_clock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld |=> ack_done);

    p_clear_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vld && is_hw && lvl_busy && !set_vld && !bus_reset)
        |=> $countones(pend_flat) == $past($countones(pend_flat)) - 1);

    p_other_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vld && !is_hw && ack_lvl != MEMERR_LVL) |=> ack_vec == '0);

    p_memerr_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vld && ack_lvl == MEMERR_LVL) |=> ack_vec == MEMERR_VEC);

    p_memerr_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vld && ack_lvl == MEMERR_LVL && !mem_err_set) |=> !mem_q);

    p_bus_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> pend_flat == '0);
endmodule

bind irq_arbiter irq_arbiter_chk #(.NLVL(NLVL), .NSRC(NSRC)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_reset  (bus_reset),
    .halt_in    (halt_in),
    .mem_err_set(mem_err_set),
    .cur_ipl    (cur_ipl),
    .set_vld    (set_vld),
    .ack_vld    (ack_vld),
    .ack_lvl    (ack_lvl),
    .irq_lvl    (irq_lvl),
    .ack_done   (ack_done),
    .ack_vec    (ack_vec),
    .mem_q      (mem_q),
    .pend_flat  (pend_flat)
);

// File: tb/sim_irq_arbiter.sv
`timescale 1ns/1ps
module sim_irq_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_reset = 1'b0;
    logic        halt_in = 1'b0;
    logic        mem_err_set = 1'b0;
    logic [4:0]  cur_ipl = '0;
    logic [15:1] sw_req = '0;
    logic        set_vld = 1'b0;
    logic [1:0]  set_lvl = '0;
    logic [4:0]  set_src = '0;
    logic [8:0]  set_base = '0;
    logic [8:0]  set_frc = '0;
    logic        ack_vld = 1'b0;
    logic [4:0]  ack_lvl = '0;
    logic [4:0]  irq_lvl;
    logic        ack_done;
    logic [8:0]  ack_vec;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    // Bench model of the pending state.
    logic [31:0] pm [4];
    int          bm [4][32];
    int          fm [4][32];
    bit          mm;

    always #2.5 clk = ~clk;

    irq_arbiter u0 (.*);

    task automatic check(string req, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got=0x%0h expected=0x%0h at %0t", req, got, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int exp_lvl();
        int ipl = int'(cur_ipl);
        if (halt_in) return 'h1F;
        if (mm && ipl < 'h1D) return 'h1D;
        for (int i = 3; i >= 0; i--) begin
            if ('h14 + i <= ipl) return 0;
            if (pm[i] != 0) return 'h14 + i;
        end
        if (ipl >= 15) return 0;
        for (int k = 15; k > ipl; k--) if (sw_req[k]) return k;
        return 0;
    endfunction

    function automatic int mkvec(int b, int f);
        return ((b | f) & (f | 'h1FC)) & 'h1FF;
    endfunction

    task automatic do_set(int l, int s, int b, int f);
        set_vld = 1; set_lvl = 2'(l); set_src = 5'(s); set_base = 9'(b); set_frc = 9'(f);
        tick();
        set_vld = 0;
        pm[l][s] = 1'b1; bm[l][s] = b; fm[l][s] = f;
    endtask

    // Acknowledge a level and compare the returned vector with the model.
    task automatic do_ack(int lvl, string req);
        int exp = 0;
        if (lvl >= 'h14 && lvl <= 'h17) begin
            int l = lvl - 'h14;
            for (int s = 31; s >= 0; s--) if (pm[l][s]) exp = mkvec(bm[l][s], fm[l][s]);
            for (int s = 0; s < 32; s++) if (pm[l][s]) begin pm[l][s] = 1'b0; break; end
        end else if (lvl == 'h1D) begin
            exp = 'h060; mm = 0;
        end
        ack_vld = 1; ack_lvl = 5'(lvl);
        tick();
        ack_vld = 0;
        check({req, " ack_done"}, int'(ack_done), 1);
        check({req, " ack_vec"}, int'(ack_vec), exp);
    endtask

    task automatic sweep_ipl(string req);
        for (int p = 0; p < 32; p++) begin
            cur_ipl = 5'(p);
            #0.5;
            check(req, int'(irq_lvl), exp_lvl());
        end
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [14:0] pats [6] = '{15'h0000, 15'h0001, 15'h4000, 15'h5555, 15'h0A40, 15'h7FFF};
        int fpats [6] = '{0, 1, 2, 3, 'h100, 'h1FF};
        for (int l = 0; l < 4; l++) pm[l] = '0;
        mm = 0;
        @(negedge clk); tick(); tick();
        rst_n = 1;
        tick();
        // R10: reset state
        check("R10 irq_lvl", int'(irq_lvl), 0);
        check("R10 ack_done", int'(ack_done), 0);
        check("R10 ack_vec", int'(ack_vec), 0);

        // R1, R4: software patterns against every priority, halt on and off
        for (int h = 0; h < 2; h++) begin
            halt_in = h[0];
            for (int q = 0; q < 6; q++) begin
                sw_req = pats[q];
                sweep_ipl(h == 1 ? "R1 halt" : "R4 software");
            end
        end
        halt_in = 0;

        // R3: hardware levels with software still requesting
        sw_req = 15'h7FFF;
        do_set(1, 5, 'h0A4, 0);
        do_set(3, 31, 'h1F0, 0);
        sweep_ipl("R3 two hw levels");
        cur_ipl = 0;
        do_ack('h17, "R5 top level");
        sweep_ipl("R3 after retire");

        // R2: memory error persists and ranks above hardware
        mem_err_set = 1; tick(); mem_err_set = 0; mm = 1;
        sweep_ipl("R2 memerr");

        // R7: acknowledge memory error, flag gone as seen at priority 0x1C
        cur_ipl = 5'h1C; #0.5;
        check("R7 before", int'(irq_lvl), 'h1D);
        do_ack('h1D, "R7");
        #0.5;
        check("R7 after", int'(irq_lvl), 0);
        cur_ipl = 0;

        // R5, R6: lowest source first, then empty and foreign levels
        do_set(1, 3, 'h1FF, 'h003);
        do_set(1, 20, 'h123, 'h100);
        do_ack('h15, "R5 src3");
        do_ack('h15, "R5 src5");
        do_ack('h15, "R5 src20");
        do_ack('h15, "R6 empty");
        do_ack('h10, "R6 foreign");
        do_ack('h1F, "R6 halt level");

        // R5: vector composition sweep
        for (int b = 0; b < 512; b += 29) begin
            for (int q = 0; q < 6; q++) begin
                do_set(0, 9, b, fpats[q]);
                do_ack('h14, "R5 vector sweep");
            end
        end

        // R8: set and clear of the same source in the same cycle
        do_set(2, 4, 'h044, 0);
        do_set(2, 7, 'h077, 0);
        set_vld = 1; set_lvl = 2; set_src = 4; set_base = 9'h0C8; set_frc = 0;
        ack_vld = 1; ack_lvl = 5'h16;
        tick();
        set_vld = 0; ack_vld = 0;
        check("R8 old vector", int'(ack_vec), 'h044);
        bm[2][4] = 'h0C8;
        do_ack('h16, "R8 still pending");
        do_ack('h16, "R8 other source");

        // R9: bus reset empties every level, beating a set
        do_set(0, 1, 'h010, 0);
        do_set(2, 2, 'h020, 0);
        do_set(3, 3, 'h030, 0);
        mem_err_set = 1; tick(); mem_err_set = 0; mm = 1;
        bus_reset = 1; set_vld = 1; set_lvl = 1; set_src = 0; set_base = 9'h050;
        tick();
        bus_reset = 0; set_vld = 0;
        for (int l = 0; l < 4; l++) pm[l] = '0;
        sw_req = '0;
        cur_ipl = 5'h1C; #0.5;
        check("R9 memerr kept", int'(irq_lvl), 'h1D);
        do_ack('h1D, "R9 clear memerr");
        cur_ipl = 0; #0.5;
        check("R9 nothing pending", int'(irq_lvl), 0);
        for (int l = 0; l < 4; l++) do_ack('h14 + l, "R9 empty level");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule